// File: doc/BRIEF.md
# Programmable Device Configuration Sequencer

This block walks a programmable logic device through its life cycle after power is applied. The cycle runs through five states in order: power-up, initialization, configuration, start-up and operation. During initialization it clears the configuration memory and holds the shared, active-low init line low. Once the line has been seen high for long enough, it samples the mode pins and starts configuration. In configuration it counts configuration clock ticks against a loaded length. It moves on only when that count matches and the end-of-configuration frame has arrived. Start-up then enables the I/O, lifts the internal reset and raises the done flag, one step per cycle. After that the device is in operation.

The init line is a wire-AND net. The device pulls it low through `init_n_o`, and it reads back the resolved level on `init_n_i`, so an external agent can also hold the device in initialization. The pins power-ok, init sense, program, reset and mode are asynchronous. Each passes through a two-stage synchronizer before the state logic uses it. The configuration clock tick, the end-frame strobe, the bit-error flag, the loaded length and the keep-memory option already belong to the `clk_i` domain.

Top module: `cfg_seq_top`

## Requirements
- R1: While `rst_ni` is low, and in the power-up state, the outputs are `init_n_o`=0, `hdc_o`=1, `ldc_o`=0, `done_o`=0, `io_en_o`=0, `int_rst_n_o`=0 and `clr_mem_o`=0. The device leaves power-up once the synchronized power-ok is high.
- R2: On every entry to initialization, `init_n_o` is held low for the first CLR_CYC cycles. `clr_mem_o` is high for exactly those cycles, unless R3 applies.
- R3: If `keep_mem_i`=1 and a configuration has completed since the last power-up, `clr_mem_o` stays low during initialization. `init_n_o` still follows R2.
- R4: While the synchronized init line is low, the device stays in initialization, whichever party holds the line low.
- R5: During initialization, a low synchronized `prgm_n_i` or `reset_n_i` keeps `init_n_o` low beyond the clear period.
- R6: After the synchronized init line reads high on two consecutive cycles, the mode is sampled into `cfg_mode_o`. A mode whose most significant bit is 1 is a slave mode, and configuration starts on the next cycle. With the length preset to 0 and the end frame held high, `io_en_o` is seen at the sixth falling edge after the init line is released.
- R7: A mode whose most significant bit is 0 is a master mode. It stays in initialization MST_XTRA (6) cycles longer than a slave mode.
- R8: During configuration, `init_n_o`=1, `hdc_o`=1, `ldc_o`=0 and `done_o`=0.
- R9: The configuration tick counter starts at zero on entry to configuration. Configuration completes only when the registered comparison "count equals `len_cnt_i`" holds and an end frame has been seen. Either condition alone does not complete it.
- R10: During configuration, a low synchronized `prgm_n_i` or `reset_n_i` returns the device to initialization.
- R11: A `bit_err_i` pulse during configuration returns the device to initialization on the next cycle, with `init_n_o` low.
- R12: Start-up sets `io_en_o` in its first cycle, `int_rst_n_o` in its second and `done_o` in its third, then enters operation. Here `ldc_o`=1 and `hdc_o`=0.
- R13: In start-up and operation, `reset_n_i` has no effect. A low `prgm_n_i` returns the device to initialization.
- R14: A low synchronized power-ok in any state returns the device to power-up and forgets any earlier completed configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply-stable indication (asynchronous) |
| init_n_i | input | 1 | Resolved level of the wire-AND init line |
| prgm_n_i | input | 1 | Active-low program request (asynchronous) |
| reset_n_i | input | 1 | Active-low configuration reset (asynchronous) |
| mode_i | input | MODE_W | Mode pins; MSB 0 = master |
| keep_mem_i | input | 1 | Skip the memory clear on reconfiguration |
| cclk_i | input | 1 | Configuration clock tick, one cycle per tick |
| end_frame_i | input | 1 | End-of-configuration frame written strobe |
| bit_err_i | input | 1 | Bitstream error flag |
| len_cnt_i | input | CNT_W | Loaded length count |
| init_n_o | output | 1 | 0 = pull the init line low |
| hdc_o | output | 1 | High during power-up, initialization and configuration |
| ldc_o | output | 1 | Low during power-up, initialization and configuration |
| done_o | output | 1 | Configuration done |
| clr_mem_o | output | 1 | Configuration memory clear request |
| int_rst_n_o | output | 1 | Internal reset, 1 = released |
| io_en_o | output | 1 | User I/O enable |
| cfg_mode_o | output | MODE_W | Mode sampled at the start of configuration |

## Verification
The bench builds the block with CLR_CYC=4, CNT_W=8 and MODE_W=3. The short clear period lets many entries to initialization fit into one run: after power-up, after program, after reset abort and after bit error. The narrow counter keeps the length comparison within a few ticks, so the count-only and frame-only completion cases can be exercised on both sides. The default INIT_HI_CYC=2 and MST_XTRA=6 are kept. This fixes the slave latency at six falling edges and the master latency at twelve, and both are checked as absolute numbers.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_INIT = 3'd1,
    ST_CFG  = 3'd2,
    ST_STUP = 3'd3,
    ST_OPER = 3'd4
  } seq_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2   // >= 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_len_cnt.sv
module cfg_len_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= !clr_i && (cnt_q == len_i);
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W      = 3,
  parameter int CLR_CYC     = 16,  // >= 2, covers the sense latency
  parameter int INIT_HI_CYC = 2,
  parameter int MST_XTRA    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_s_i,
  input  logic              init_s_i,
  input  logic              prgm_s_i,
  input  logic              reset_s_i,
  input  logic [MODE_W-1:0] mode_s_i,
  input  logic              keep_mem_i,
  input  logic              end_frame_i,
  input  logic              bit_err_i,
  input  logic              match_i,
  output logic              cnt_clr_o,
  output logic              init_n_o,
  output logic              hdc_o,
  output logic              ldc_o,
  output logic              done_o,
  output logic              clr_mem_o,
  output logic              int_rst_n_o,
  output logic              io_en_o,
  output logic [MODE_W-1:0] cfg_mode_o
);
  localparam int HI_MAX = INIT_HI_CYC + MST_XTRA;
  localparam int HI_W   = $clog2(HI_MAX + 1);
  localparam int CLR_W  = $clog2(CLR_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [CLR_W-1:0]  clr_cnt_q;
  logic [HI_W-1:0]   hi_cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic              once_q, eof_q;
  logic [1:0]        stup_q;

  logic drive_low, sensed_ok, mst_now, init_go, clearing, abort_cfg;
  int   need;

  always_comb begin
    clearing  = clr_cnt_q < CLR_W'(CLR_CYC);
    drive_low = (state_q == ST_INIT) && (clearing || !prgm_s_i || !reset_s_i);
    sensed_ok = init_s_i && !drive_low;
    mst_now   = (hi_cnt_q < HI_W'(INIT_HI_CYC)) ? !mode_s_i[MODE_W-1] : !mode_q[MODE_W-1];
    need      = INIT_HI_CYC - 1 + (mst_now ? MST_XTRA : 0);
    init_go   = (state_q == ST_INIT) && sensed_ok && (hi_cnt_q == HI_W'(need));
    abort_cfg = !prgm_s_i || !reset_s_i || bit_err_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWR:  if (pwr_s_i) state_d = ST_INIT;
      ST_INIT: if (init_go) state_d = ST_CFG;
      ST_CFG: begin
        if (abort_cfg)             state_d = ST_INIT;
        else if (match_i && eof_q) state_d = ST_STUP;
      end
      ST_STUP: begin
        if (!prgm_s_i)         state_d = ST_INIT;
        else if (stup_q == 2'd2) state_d = ST_OPER;
      end
      ST_OPER: if (!prgm_s_i) state_d = ST_INIT;
      default: state_d = ST_PWR;
    endcase
    if (!pwr_s_i) state_d = ST_PWR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PWR;
      clr_cnt_q <= '0;
      hi_cnt_q  <= '0;
      mode_q    <= '0;
      once_q    <= 1'b0;
      eof_q     <= 1'b0;
      stup_q    <= '0;
    end else begin
      state_q <= state_d;

      if (state_q != ST_INIT) clr_cnt_q <= '0;
      else if (clearing)      clr_cnt_q <= clr_cnt_q + 1'b1;

      if (state_q != ST_INIT || !sensed_ok)  hi_cnt_q <= '0;
      else if (hi_cnt_q != HI_W'(HI_MAX))    hi_cnt_q <= hi_cnt_q + 1'b1;

      if (state_q == ST_INIT && sensed_ok && hi_cnt_q == HI_W'(INIT_HI_CYC - 1))
        mode_q <= mode_s_i;

      if (state_q == ST_PWR)       once_q <= 1'b0;
      else if (state_q == ST_STUP) once_q <= 1'b1;

      eof_q  <= (state_q == ST_CFG) && (eof_q || end_frame_i);
      stup_q <= (state_q == ST_STUP) ? stup_q + 1'b1 : 2'd0;
    end
  end

  always_comb begin
    cnt_clr_o   = state_q != ST_CFG;
    init_n_o    = (state_q == ST_CFG) || (state_q == ST_STUP) || (state_q == ST_OPER) ||
                  ((state_q == ST_INIT) && !drive_low);
    hdc_o       = (state_q == ST_PWR) || (state_q == ST_INIT) || (state_q == ST_CFG);
    ldc_o       = !hdc_o;
    io_en_o     = (state_q == ST_STUP) || (state_q == ST_OPER);
    int_rst_n_o = (state_q == ST_OPER) || ((state_q == ST_STUP) && stup_q >= 2'd1);
    done_o      = (state_q == ST_OPER) || ((state_q == ST_STUP) && stup_q >= 2'd2);
    clr_mem_o   = (state_q == ST_INIT) && clearing && !(keep_mem_i && once_q);
    cfg_mode_o  = mode_q;
  end
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
  parameter int MODE_W      = 3,
  parameter int CNT_W       = 16,
  parameter int CLR_CYC     = 16,
  parameter int INIT_HI_CYC = 2,
  parameter int MST_XTRA    = 6,
  parameter int SYNC_STG    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              init_n_i,
  input  logic              prgm_n_i,
  input  logic              reset_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              keep_mem_i,
  input  logic              cclk_i,
  input  logic              end_frame_i,
  input  logic              bit_err_i,
  input  logic [CNT_W-1:0]  len_cnt_i,
  output logic              init_n_o,
  output logic              hdc_o,
  output logic              ldc_o,
  output logic              done_o,
  output logic              clr_mem_o,
  output logic              int_rst_n_o,
  output logic              io_en_o,
  output logic [MODE_W-1:0] cfg_mode_o
);
  localparam int SW = MODE_W + 4;

  logic [SW-1:0]     pin_s;
  logic              pwr_s, init_s, prgm_s, reset_s;
  logic [MODE_W-1:0] mode_s;
  logic              cnt_clr, match;

  cfg_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwr_ok_i, init_n_i, prgm_n_i, reset_n_i, mode_i}),
    .q_o   (pin_s)
  );

  assign {pwr_s, init_s, prgm_s, reset_s, mode_s} = pin_s;

  cfg_len_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (cclk_i),
    .len_i  (len_cnt_i),
    .match_o(match)
  );

  cfg_fsm #(
    .MODE_W(MODE_W), .CLR_CYC(CLR_CYC), .INIT_HI_CYC(INIT_HI_CYC), .MST_XTRA(MST_XTRA)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_s_i    (pwr_s),
    .init_s_i   (init_s),
    .prgm_s_i   (prgm_s),
    .reset_s_i  (reset_s),
    .mode_s_i   (mode_s),
    .keep_mem_i (keep_mem_i),
    .end_frame_i(end_frame_i),
    .bit_err_i  (bit_err_i),
    .match_i    (match),
    .cnt_clr_o  (cnt_clr),
    .init_n_o   (init_n_o),
    .hdc_o      (hdc_o),
    .ldc_o      (ldc_o),
    .done_o     (done_o),
    .clr_mem_o  (clr_mem_o),
    .int_rst_n_o(int_rst_n_o),
    .io_en_o    (io_en_o),
    .cfg_mode_o (cfg_mode_o)
  );
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic init_n_o,
  input logic hdc_o,
  input logic done_o,
  input logic clr_mem_o,
  input logic int_rst_n_o,
  input logic io_en_o,
  input logic prgm_s,
  input logic pwr_s
);
  AST_INIT_LOW_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_n_o |-> !done_o); // R1
  AST_CLR_HOLDS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_mem_o |-> !init_n_o); // R2
  AST_HDC_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdc_o |-> !done_o); // R8
  AST_IO_FROM_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_en_o) |-> $past(hdc_o) && $past(init_n_o)); // R9
  AST_DONE_IMPLIES_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> io_en_o && int_rst_n_o); // R12
  AST_DONE_AFTER_RST_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(int_rst_n_o)); // R12
  AST_RESET_IGNORED_OPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && prgm_s && pwr_s |=> done_o); // R13
  AST_PWR_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_s |=> !done_o && !init_n_o); // R14
endmodule

bind cfg_seq_top cfg_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_n_o   (init_n_o),
  .hdc_o      (hdc_o),
  .done_o     (done_o),
  .clr_mem_o  (clr_mem_o),
  .int_rst_n_o(int_rst_n_o),
  .io_en_o    (io_en_o),
  .prgm_s     (prgm_s),
  .pwr_s      (pwr_s)
);

// File: tb/sim_cfg_seq_top.sv
module sim_cfg_seq_top;
  localparam int MODE_W = 3, CNT_W = 8, CLR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic pwr_ok = 0, ext_n = 0, prgm_n = 1, reset_n = 1, keep = 0;
  logic cclk = 0, eoc = 0, berr = 0;
  logic [MODE_W-1:0] mode = 3'b100;
  logic [CNT_W-1:0]  len  = '0;

  logic init_o, hdc, ldc, done, clr, irst_n, io_en;
  logic [MODE_W-1:0] cmode;
  wire init_line = init_o & ext_n;

  cfg_seq_top #(.MODE_W(MODE_W), .CNT_W(CNT_W), .CLR_CYC(CLR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .init_n_i(init_line),
    .prgm_n_i(prgm_n), .reset_n_i(reset_n), .mode_i(mode), .keep_mem_i(keep),
    .cclk_i(cclk), .end_frame_i(eoc), .bit_err_i(berr), .len_cnt_i(len),
    .init_n_o(init_o), .hdc_o(hdc), .ldc_o(ldc), .done_o(done), .clr_mem_o(clr),
    .int_rst_n_o(irst_n), .io_en_o(io_en), .cfg_mode_o(cmode)
  );

  int checks = 0, fails = 0, clr_seen = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference model: states 0 pwr,1 init,2 cfg,3 startup,4 oper
  int m_st, m_clr, m_hi, m_mode, m_once, m_eof, m_stup, m_cnt, m_match;
  bit p1, p2, i1, i2, g1, g2, r1, r2;
  int md1, md2;

  function automatic bit m_dl();
    return m_st == 1 && (m_clr < CLR || !g2 || !r2);
  endfunction
  function automatic bit m_init();
    return m_st >= 2 || (m_st == 1 && !m_dl());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_clr = 0; m_hi = 0; m_mode = 0; m_once = 0; m_eof = 0;
      m_stup = 0; m_cnt = 0; m_match = 0;
      p1 = 0; p2 = 0; i1 = 0; i2 = 0; g1 = 0; g2 = 0; r1 = 0; r2 = 0; md1 = 0; md2 = 0;
    end else begin
      bit line, ok, mst, go;
      int nst;
      line = m_init() & ext_n;
      ok   = i2 && !m_dl();
      mst  = (m_hi < 2) ? !md2[2] : !m_mode[2];
      go   = m_st == 1 && ok && m_hi == (mst ? 7 : 1);
      nst  = m_st;
      case (m_st)
        0: if (p2) nst = 1;
        1: if (go) nst = 2;
        2: if (!g2 || !r2 || berr) nst = 1; else if (m_match && m_eof) nst = 3;
        3: if (!g2) nst = 1; else if (m_stup == 2) nst = 4;
        4: if (!g2) nst = 1;
        default: nst = 0;
      endcase
      if (!p2) nst = 0;
      if (m_st == 1 && ok && m_hi == 1) m_mode = md2;
      m_clr   = (m_st == 1) ? ((m_clr < CLR) ? m_clr + 1 : m_clr) : 0;
      m_hi    = (m_st == 1 && ok) ? m_hi + 1 : 0;
      if (m_st == 0) m_once = 0; else if (m_st == 3) m_once = 1;
      m_match = (m_st == 2 && m_cnt == int'(len));
      m_cnt   = (m_st == 2) ? ((m_cnt + int'(cclk)) % 256) : 0;
      m_eof   = (m_st == 2) ? (m_eof | int'(eoc)) : 0;
      m_stup  = (m_st == 3) ? m_stup + 1 : 0;
      p2 = p1; p1 = pwr_ok; i2 = i1; i1 = line;
      g2 = g1; g1 = prgm_n; r2 = r1; r1 = reset_n; md2 = md1; md1 = int'(mode);
      m_st = nst;
    end
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk); #2;
    if (!finished) begin
      chk("R2 init_n_o", init_o, m_init());
      chk("R8 hdc_o", hdc, m_st <= 2);
      chk("R12 ldc_o", ldc, m_st >= 3);
      chk("R12 io_en_o", io_en, m_st >= 3);
      chk("R12 int_rst_n_o", irst_n, m_st == 4 || (m_st == 3 && m_stup >= 1));
      chk("R12 done_o", done, m_st == 4 || (m_st == 3 && m_stup >= 2));
      chk("R3 clr_mem_o", clr, m_st == 1 && m_clr < CLR && !(keep && m_once));
      chk("R6 cfg_mode_o", int'(cmode), m_mode);
      if (clr) clr_seen++;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cclk();
    cclk = 1; wait_n(1); cclk = 0; wait_n(1);
  endtask

  task automatic measure(output int lat);
    ext_n = 1;
    lat = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #2;
      lat++;
      if (io_en) break;
    end
  endtask

  task automatic report();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int lat;
    wait_n(3);
    chk("R1 init_n_o in reset", init_o, 0);
    chk("R1 hdc_o in reset", hdc, 1);
    chk("R1 done_o in reset", done, 0);
    chk("R1 io/rst/clr in reset", {io_en, irst_n, clr}, 0);
    rst_n = 1;
    wait_n(6);
    chk("R1 power-up holds init low", init_o, 0);

    clr_seen = 0;
    pwr_ok = 1;
    wait_n(20);
    chk("R2 clear cycles first init", clr_seen, CLR);
    chk("R4 init released by device", init_o, 1);
    eoc = 1; len = 0;
    wait_n(10);
    chk("R4 external hold keeps init", io_en, 0);

    measure(lat);
    chk("R6 slave latency", lat, 6);
    wait_n(5);
    chk("R12 done after start-up", done, 1);
    chk("R6 sampled mode", int'(cmode), 4);

    reset_n = 0;
    wait_n(10);
    chk("R13 reset ignored in operation", done, 1);
    reset_n = 1;
    wait_n(3);

    keep = 1; clr_seen = 0; ext_n = 0; mode = 3'b001;
    prgm_n = 0;
    wait_n(20);
    chk("R13 program leaves operation", done, 0);
    chk("R5 program holds init low", init_o, 0);
    chk("R3 clear skipped", clr_seen, 0);
    prgm_n = 1;
    wait_n(10);
    measure(lat);
    chk("R7 master latency", lat, 12);
    chk("R7 sampled mode", int'(cmode), 1);
    wait_n(5);

    eoc = 0; len = 50;
    prgm_n = 0; wait_n(5); prgm_n = 1;
    wait_n(30);
    chk("R8 cfg init_n_o", init_o, 1);
    chk("R8 cfg hdc/ldc", {hdc, ldc}, 2);
    chk("R8 cfg done_o", done, 0);
    prgm_n = 0;
    wait_n(5);
    chk("R10 program aborts cfg", init_o, 0);
    prgm_n = 1;
    wait_n(30);
    reset_n = 0;
    wait_n(5);
    chk("R10 reset aborts cfg", init_o, 0);
    reset_n = 1;
    wait_n(30);
    berr = 1;
    wait_n(1);
    berr = 0;
    chk("R11 bit error to init", init_o, 0);
    wait_n(30);

    len = 3;
    pulse_cclk(); pulse_cclk(); pulse_cclk();
    wait_n(5);
    chk("R9 count alone", io_en, 0);
    eoc = 1; wait_n(1); eoc = 0;
    wait_n(5);
    chk("R9 count and frame", io_en, 1);

    prgm_n = 0; wait_n(5); prgm_n = 1;
    wait_n(30);
    eoc = 1; wait_n(1); eoc = 0;
    pulse_cclk(); pulse_cclk();
    wait_n(5);
    chk("R9 frame alone", io_en, 0);
    pulse_cclk();
    wait_n(5);
    chk("R9 frame then count", io_en, 1);
    wait_n(5);

    clr_seen = 0;
    pwr_ok = 0;
    wait_n(4);
    chk("R14 power loss done", done, 0);
    chk("R14 power loss init", init_o, 0);
    pwr_ok = 1;
    wait_n(20);
    chk("R14 clear after power loss", clr_seen, CLR);
    wait_n(5);
    report();
  end
endmodule